// File: doc/BRIEF.md
# Command Slot List Manager

This block keeps a pool of command-control slots organised as three linked lists that share one slot store. Each slot holds a forward link, a backward link, a tag byte and a disconnected flag. The waiting list is singly linked and behaves as a stack: the most recently pushed slot is selected first. The free list is singly linked and also handed out newest first. The disconnected list is doubly linked, so any member can be removed in constant time without walking the list.

A controller issues one operation at a time: push or pop the waiting list, return a slot to the free pool, allocate a slot, park a slot as disconnected with its tag, remove a given slot from the disconnected list, or search the pool for a disconnected slot by tag. Allocation prefers the free list and falls back to taking the newest disconnected slot. The all-ones index is the null link and the null result. Every operation except the search finishes in one cycle after acceptance; the search visits one slot per cycle.

Top module: `cmd_slot_lists`

## Requirements
- R1: After reset all three head outputs read 0xFF, busy_o is low and done_o is low.
- R2: Push waiting (op_i 0) makes slot_i the waiting head and returns it; pop waiting (op_i 1) returns the current waiting head and makes its successor the head, so slots leave in reverse push order; pop on an empty list returns 0xFF.
- R3: Add free (op_i 2) makes slot_i the free head and returns it; take free (op_i 3) returns the free head and advances the free head, newest first.
- R4: A slot added to the free list has its tag set to 0xFF and its disconnected flag cleared, so a later search never returns it.
- R5: Add disconnected (op_i 4) stores tag_i in slot_i, sets its flag, places it at the head of the disconnected list and returns it.
- R6: Remove disconnected (op_i 5) unlinks slot_i from the head, middle or tail of the disconnected list, returns slot_i, and leaves the remaining members in their previous order.
- R7: Take free with an empty free list removes and returns the disconnected head; with both lists empty it returns 0xFF and changes nothing.
- R8: Search (op_i 6) returns the lowest slot index at or above start_i, below the slot count, whose flag is set and whose tag equals tag_i, or 0xFF when there is none or start_i is not below the slot count; it changes no list.
- R9: Remove disconnected of a slot whose flag is clear returns 0xFF and leaves all heads unchanged.
- R10: Push waiting, add free, add disconnected and remove disconnected with slot_i not below the slot count, and op_i 7, return 0xFF and change nothing.
- R11: A request is accepted on a clock edge where req_valid_i is high and busy_o is low; busy_o is then high until the result edge, where done_o pulses for one cycle with result_o. Non-search operations take one cycle; a search from start s that hits slot h takes h-s+1 cycles, a miss takes NUM_SLOTS-s cycles (one cycle if s is out of range).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Operation request, taken when busy_o is low |
| op_i | input | 3 | Operation code (0..6, 7 is a no-op) |
| slot_i | input | SLOT_W | Slot index operand |
| tag_i | input | TAG_W | Tag for add disconnected and search |
| start_i | input | SLOT_W | First slot examined by a search |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse, result_o valid |
| result_o | output | SLOT_W | Slot returned, or all ones for none |
| wait_head_o | output | SLOT_W | Head of the waiting list |
| free_head_o | output | SLOT_W | Head of the free list |
| disc_head_o | output | SLOT_W | Head of the disconnected list |

## Verification
The link invariants checked in the RTL, such as a null backward link on the disconnected head and an untagged free head, rely on the controller never adding a slot that already sits on another list and on requests being raised only while busy_o is low. The directed stimulus keeps every slot on at most one of the free and disconnected lists at a time and waits for done_o before each new request. A queue-based reference model predicts each result, each head and each search latency, so removal from every list position and the allocation fallback are compared against list order rather than pointer values.

// File: rtl/slot_list_pkg.sv
package slot_list_pkg;
  localparam logic [2:0] OP_PUSH_WAIT = 3'd0;
  localparam logic [2:0] OP_POP_WAIT  = 3'd1;
  localparam logic [2:0] OP_ADD_FREE  = 3'd2;
  localparam logic [2:0] OP_TAKE_FREE = 3'd3;
  localparam logic [2:0] OP_ADD_DISC  = 3'd4;
  localparam logic [2:0] OP_REM_DISC  = 3'd5;
  localparam logic [2:0] OP_FIND_TAG  = 3'd6;
endpackage

// File: rtl/slot_store.sv
module slot_store #(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 8,
  parameter int TAG_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_we_i,
  input  logic [SLOT_W-1:0] a_idx_i,
  input  logic              a_set_next_i,
  input  logic              a_set_prev_i,
  input  logic              a_set_tag_i,
  input  logic              a_set_flag_i,
  input  logic [SLOT_W-1:0] a_next_i,
  input  logic [SLOT_W-1:0] a_prev_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic              a_flag_i,
  input  logic              b_we_i,
  input  logic [SLOT_W-1:0] b_idx_i,
  input  logic [SLOT_W-1:0] b_prev_i,
  input  logic              c_we_i,
  input  logic [SLOT_W-1:0] c_idx_i,
  input  logic [SLOT_W-1:0] c_next_i,
  output logic [SLOT_W-1:0] nxt_o [NUM_SLOTS],
  output logic [SLOT_W-1:0] prv_o [NUM_SLOTS],
  output logic [TAG_W-1:0]  tag_o [NUM_SLOTS],
  output logic [NUM_SLOTS-1:0] flag_o
);
  localparam logic [SLOT_W-1:0] NULL_IDX = '1;
  localparam logic [TAG_W-1:0]  NULL_TAG = '1;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [SLOT_W-1:0] SI = SLOT_W'(s);
    logic [SLOT_W-1:0] nxt_q, prv_q;
    logic [TAG_W-1:0]  tag_q;
    logic              flag_q;
    logic              a_hit;
    assign a_hit = a_we_i && (a_idx_i == SI);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        nxt_q  <= NULL_IDX;
        prv_q  <= NULL_IDX;
        tag_q  <= NULL_TAG;
        flag_q <= 1'b0;
      end else begin
        if (a_hit && a_set_next_i)          nxt_q <= a_next_i;
        else if (c_we_i && c_idx_i == SI)   nxt_q <= c_next_i;
        if (a_hit && a_set_prev_i)          prv_q <= a_prev_i;
        else if (b_we_i && b_idx_i == SI)   prv_q <= b_prev_i;
        if (a_hit && a_set_tag_i)           tag_q <= a_tag_i;
        if (a_hit && a_set_flag_i)          flag_q <= a_flag_i;
      end
    end

    assign nxt_o[s]  = nxt_q;
    assign prv_o[s]  = prv_q;
    assign tag_o[s]  = tag_q;
    assign flag_o[s] = flag_q;
  end
endmodule

// File: rtl/tag_scan.sv
module tag_scan #(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 8,
  parameter int TAG_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] start_i,
  input  logic              step_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [TAG_W-1:0]  tags_i [NUM_SLOTS],
  input  logic [NUM_SLOTS-1:0] flags_i,
  output logic [SLOT_W-1:0] idx_o,
  output logic              hit_o,
  output logic              last_o
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [SLOT_W:0] LIMIT = (SLOT_W+1)'(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] TOP_IDX = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] idx_q;
  logic              in_rng;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (load_i) idx_q <= start_i;
    else if (step_i) idx_q <= idx_q + 1'b1;
  end

  assign in_rng = {1'b0, idx_q} < LIMIT;
  assign hit_o  = in_rng && flags_i[idx_q[IDX_W-1:0]] && (tags_i[idx_q[IDX_W-1:0]] == tag_i);
  assign last_o = !in_rng || (idx_q == TOP_IDX);
  assign idx_o  = idx_q;

  // R8: the scan moves up by exactly one slot per step
  a_r8_scan_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> idx_o == $past(idx_o) + 1'b1);
  // R8: a step never leaves the slot range
  a_r8_scan_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> {1'b0, idx_o} < LIMIT - 1);
endmodule

// File: rtl/cmd_slot_lists.sv
module cmd_slot_lists
  import slot_list_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 8,
  parameter int TAG_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        op_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [SLOT_W-1:0] start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SLOT_W-1:0] result_o,
  output logic [SLOT_W-1:0] wait_head_o,
  output logic [SLOT_W-1:0] free_head_o,
  output logic [SLOT_W-1:0] disc_head_o
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [SLOT_W:0]   LIMIT    = (SLOT_W+1)'(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] NULL_IDX = '1;
  localparam logic [TAG_W-1:0]  NULL_TAG = '1;

  function automatic logic in_rng(input logic [SLOT_W-1:0] x);
    return {1'b0, x} < LIMIT;
  endfunction

  logic              busy_q, done_q;
  logic [2:0]        op_q;
  logic [SLOT_W-1:0] slot_q, result_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SLOT_W-1:0] wait_q, free_q, disc_q;
  logic [SLOT_W-1:0] wait_n, free_n, disc_n, res_n;

  logic [SLOT_W-1:0] nxt [NUM_SLOTS];
  logic [SLOT_W-1:0] prv [NUM_SLOTS];
  logic [TAG_W-1:0]  tag [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] flag;

  logic              a_we, a_set_next, a_set_prev, a_set_tag, a_set_flag, a_flag;
  logic [SLOT_W-1:0] a_idx, a_next, a_prev;
  logic [TAG_W-1:0]  a_tag;
  logic              b_we, c_we;
  logic [SLOT_W-1:0] b_idx, b_prev, c_idx, c_next;

  logic              is_find, exec, finish, scan_hit, scan_last, do_unlink, slot_ok;
  logic [SLOT_W-1:0] scan_idx, victim, v_next, v_prev, wait_succ, free_succ;
  logic              v_flag;

  slot_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni,
    .a_we_i(a_we), .a_idx_i(a_idx), .a_set_next_i(a_set_next), .a_set_prev_i(a_set_prev),
    .a_set_tag_i(a_set_tag), .a_set_flag_i(a_set_flag), .a_next_i(a_next), .a_prev_i(a_prev),
    .a_tag_i(a_tag), .a_flag_i(a_flag),
    .b_we_i(b_we), .b_idx_i(b_idx), .b_prev_i(b_prev),
    .c_we_i(c_we), .c_idx_i(c_idx), .c_next_i(c_next),
    .nxt_o(nxt), .prv_o(prv), .tag_o(tag), .flag_o(flag)
  );

  assign is_find = (op_q == OP_FIND_TAG);
  assign exec    = busy_q && !is_find;
  assign finish  = busy_q && (!is_find || scan_hit || scan_last);

  tag_scan #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_scan (
    .clk_i, .rst_ni,
    .load_i(!busy_q && req_valid_i), .start_i(start_i),
    .step_i(busy_q && is_find && !scan_hit && !scan_last),
    .tag_i(tag_q), .tags_i(tag), .flags_i(flag),
    .idx_o(scan_idx), .hit_o(scan_hit), .last_o(scan_last)
  );

  assign slot_ok   = in_rng(slot_q);
  assign victim    = (op_q == OP_TAKE_FREE) ? disc_q : slot_q;
  assign v_next    = in_rng(victim) ? nxt[victim[IDX_W-1:0]] : NULL_IDX;
  assign v_prev    = in_rng(victim) ? prv[victim[IDX_W-1:0]] : NULL_IDX;
  assign v_flag    = in_rng(victim) && flag[victim[IDX_W-1:0]];
  assign wait_succ = in_rng(wait_q) ? nxt[wait_q[IDX_W-1:0]] : NULL_IDX;
  assign free_succ = in_rng(free_q) ? nxt[free_q[IDX_W-1:0]] : NULL_IDX;

  always_comb begin
    a_we = 1'b0; a_set_next = 1'b0; a_set_prev = 1'b0; a_set_tag = 1'b0; a_set_flag = 1'b0;
    a_idx = victim; a_next = NULL_IDX; a_prev = NULL_IDX; a_tag = NULL_TAG; a_flag = 1'b0;
    b_we = 1'b0; b_idx = NULL_IDX; b_prev = NULL_IDX;
    c_we = 1'b0; c_idx = NULL_IDX; c_next = NULL_IDX;
    wait_n = wait_q; free_n = free_q; disc_n = disc_q;
    res_n = NULL_IDX; do_unlink = 1'b0;
    if (exec) begin
      case (op_q)
        OP_PUSH_WAIT: if (slot_ok) begin
          a_we = 1'b1; a_set_next = 1'b1; a_next = wait_q;
          wait_n = slot_q; res_n = slot_q;
        end
        OP_POP_WAIT: if (wait_q != NULL_IDX) begin
          res_n = wait_q; wait_n = wait_succ;
        end
        OP_ADD_FREE: if (slot_ok) begin
          a_we = 1'b1; a_set_next = 1'b1; a_next = free_q;
          a_set_tag = 1'b1; a_tag = NULL_TAG; a_set_flag = 1'b1; a_flag = 1'b0;
          free_n = slot_q; res_n = slot_q;
        end
        OP_TAKE_FREE: begin
          if (free_q != NULL_IDX) begin
            res_n = free_q; free_n = free_succ;
          end else if (disc_q != NULL_IDX) begin
            do_unlink = 1'b1;
          end
        end
        OP_ADD_DISC: if (slot_ok) begin
          a_we = 1'b1; a_set_next = 1'b1; a_next = disc_q;
          a_set_prev = 1'b1; a_prev = NULL_IDX;
          a_set_tag = 1'b1; a_tag = tag_q; a_set_flag = 1'b1; a_flag = 1'b1;
          if (disc_q != NULL_IDX) begin
            b_we = 1'b1; b_idx = disc_q; b_prev = slot_q;
          end
          disc_n = slot_q; res_n = slot_q;
        end
        OP_REM_DISC: if (slot_ok && v_flag) do_unlink = 1'b1;
        default: ;
      endcase
      if (do_unlink) begin
        a_we = 1'b1; a_set_flag = 1'b1; a_flag = 1'b0;
        if (v_next != NULL_IDX) begin
          b_we = 1'b1; b_idx = v_next; b_prev = v_prev;
        end
        if (v_prev == NULL_IDX) disc_n = v_next;
        else begin
          c_we = 1'b1; c_idx = v_prev; c_next = v_next;
        end
        res_n = victim;
      end
    end else if (finish) begin
      res_n = scan_hit ? scan_idx : NULL_IDX;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; op_q <= '0;
      slot_q <= NULL_IDX; tag_q <= '0; result_q <= NULL_IDX;
      wait_q <= NULL_IDX; free_q <= NULL_IDX; disc_q <= NULL_IDX;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i) begin
          busy_q <= 1'b1; op_q <= op_i; slot_q <= slot_i; tag_q <= tag_i;
        end
      end else if (finish) begin
        busy_q <= 1'b0; done_q <= 1'b1; result_q <= res_n;
        wait_q <= wait_n; free_q <= free_n; disc_q <= disc_n;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign result_o    = result_q;
  assign wait_head_o = wait_q;
  assign free_head_o = free_q;
  assign disc_head_o = disc_q;

  // R11: the result pulse never overlaps a running operation
  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R11: an accepted request makes the block busy
  a_r11_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o);
  // R11: heads only move on a result edge
  a_r11_heads_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({wait_q, free_q, disc_q}) |-> done_o);
  // R10: every head is null or a valid slot
  a_r10_heads_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q == NULL_IDX || in_rng(wait_q)) && (free_q == NULL_IDX || in_rng(free_q)) &&
    (disc_q == NULL_IDX || in_rng(disc_q)));
  // R5: the disconnected head has no predecessor and is flagged
  a_r5_disc_head_linked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rng(disc_q) |-> prv[disc_q[IDX_W-1:0]] == NULL_IDX && flag[disc_q[IDX_W-1:0]]);
  // R4: the free head carries no tag and no flag
  a_r4_free_head_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rng(free_q) |-> tag[free_q[IDX_W-1:0]] == NULL_TAG && !flag[free_q[IDX_W-1:0]]);
  // R8: a search hit names a flagged slot with the requested tag
  a_r8_find_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && is_find && in_rng(result_q) |->
      flag[result_q[IDX_W-1:0]] && tag[result_q[IDX_W-1:0]] == tag_q);
endmodule

// File: tb/test_cmd_slot_lists.sv
module test_cmd_slot_lists;
  localparam int N = 16;
  localparam int NUL = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] slot = '0, tag = '0, start = '0;
  logic busy, done;
  logic [7:0] result, wait_head, free_head, disc_head;

  always #10 clk = ~clk;

  cmd_slot_lists #(.NUM_SLOTS(N), .SLOT_W(8), .TAG_W(8)) i_cmd_slot_lists (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .op_i(op), .slot_i(slot),
    .tag_i(tag), .start_i(start), .busy_o(busy), .done_o(done), .result_o(result),
    .wait_head_o(wait_head), .free_head_o(free_head), .disc_head_o(disc_head)
  );

  int n_chk = 0, n_fail = 0;
  int wait_m[$], free_m[$], disc_m[$];
  int tag_m[N];

  task automatic check_eq(input string req_id, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req_id, what, act, exp);
    end
  endtask

  function automatic int disc_pos(input int s);
    foreach (disc_m[k]) if (disc_m[k] == s) return k;
    return -1;
  endfunction

  task automatic run_op(input int o, input int s, input int t, input int st, input string req_id);
    int exp_res = NUL, exp_lat = 1, lat = 0, k;
    case (o)
      0: if (s < N) begin wait_m.push_front(s); exp_res = s; end
      1: if (wait_m.size() > 0) exp_res = wait_m.pop_front();
      2: if (s < N) begin free_m.push_front(s); tag_m[s] = NUL; exp_res = s; end
      3: if (free_m.size() > 0) exp_res = free_m.pop_front();
         else if (disc_m.size() > 0) exp_res = disc_m.pop_front();
      4: if (s < N) begin disc_m.push_front(s); tag_m[s] = t; exp_res = s; end
      5: begin
        k = (s < N) ? disc_pos(s) : -1;
        if (k >= 0) begin disc_m.delete(k); exp_res = s; end
      end
      6: begin
        for (int i = st; i < N; i++)
          if (exp_res == NUL && disc_pos(i) >= 0 && tag_m[i] == t) exp_res = i;
        exp_lat = (exp_res != NUL) ? exp_res - st + 1 : ((st < N) ? N - st : 1);
      end
      default: ;
    endcase
    @(negedge clk);
    req = 1'b1; op = 3'(o); slot = 8'(s); tag = 8'(t); start = 8'(st);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    check_eq("R11", "busy after accept", int'(busy), 1);
    while (!done && lat < 4 * N) begin
      @(negedge clk);
      lat++;
    end
    check_eq(req_id, "result", int'(result), exp_res);
    check_eq("R11", "latency", lat, exp_lat);
    check_eq(req_id, "wait head", int'(wait_head), (wait_m.size() > 0) ? wait_m[0] : NUL);
    check_eq(req_id, "free head", int'(free_head), (free_m.size() > 0) ? free_m[0] : NUL);
    check_eq(req_id, "disc head", int'(disc_head), (disc_m.size() > 0) ? disc_m[0] : NUL);
    @(negedge clk);
    check_eq("R11", "done pulse width", int'(done), 0);
  endtask

  task automatic t_reset;
    check_eq("R1", "wait head", int'(wait_head), NUL);
    check_eq("R1", "free head", int'(free_head), NUL);
    check_eq("R1", "disc head", int'(disc_head), NUL);
    check_eq("R1", "busy", int'(busy), 0);
    check_eq("R1", "done", int'(done), 0);
  endtask

  task automatic t_waiting;
    run_op(1, 0, 0, 0, "R2");
    run_op(0, 3, 0, 0, "R2");
    run_op(0, 7, 0, 0, "R2");
    run_op(0, 1, 0, 0, "R2");
    run_op(1, 0, 0, 0, "R2");
    run_op(1, 0, 0, 0, "R2");
    run_op(0, 9, 0, 0, "R2");
    run_op(1, 0, 0, 0, "R2");
    run_op(1, 0, 0, 0, "R2");
    run_op(1, 0, 0, 0, "R2");
  endtask

  task automatic t_free;
    run_op(3, 0, 0, 0, "R7");
    run_op(2, 2, 0, 0, "R3");
    run_op(2, 5, 0, 0, "R3");
    run_op(3, 0, 0, 0, "R3");
    run_op(3, 0, 0, 0, "R3");
  endtask

  task automatic t_disc_remove;
    run_op(4, 10, 8'h21, 0, "R5");
    run_op(4, 11, 8'h22, 0, "R5");
    run_op(4, 12, 8'h23, 0, "R5");
    run_op(4, 13, 8'h24, 0, "R5");
    run_op(5, 12, 0, 0, "R6");
    run_op(5, 13, 0, 0, "R6");
    run_op(5, 10, 0, 0, "R6");
    run_op(4, 14, 8'h25, 0, "R5");
    run_op(3, 0, 0, 0, "R7");
    run_op(3, 0, 0, 0, "R7");
    run_op(3, 0, 0, 0, "R7");
  endtask

  task automatic t_ignored;
    run_op(4, 6, 8'h01, 0, "R5");
    run_op(5, 4, 0, 0, "R9");
    run_op(0, 20, 0, 0, "R10");
    run_op(4, 255, 8'h02, 0, "R10");
    run_op(2, 16, 0, 0, "R10");
    run_op(5, 200, 0, 0, "R10");
    run_op(7, 6, 0, 0, "R10");
    run_op(5, 6, 0, 0, "R6");
    run_op(5, 6, 0, 0, "R9");
  endtask

  task automatic t_search;
    run_op(4, 3, 8'h40, 0, "R5");
    run_op(4, 8, 8'h40, 0, "R5");
    run_op(4, 12, 8'h41, 0, "R5");
    run_op(6, 0, 8'h40, 0, "R8");
    run_op(6, 0, 8'h40, 4, "R8");
    run_op(6, 0, 8'h40, 9, "R8");
    run_op(6, 0, 8'h41, 12, "R8");
    run_op(6, 0, 8'h41, 20, "R8");
    run_op(6, 0, 8'h55, 0, "R8");
    run_op(5, 3, 0, 0, "R6");
    run_op(2, 3, 0, 0, "R4");
    run_op(5, 8, 0, 0, "R6");
    run_op(2, 8, 0, 0, "R4");
    run_op(6, 0, 8'h40, 0, "R4");
  endtask

  task automatic t_alloc_order;
    run_op(3, 0, 0, 0, "R7");
    run_op(3, 0, 0, 0, "R7");
    run_op(3, 0, 0, 0, "R7");
    run_op(3, 0, 0, 0, "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) tag_m[i] = NUL;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_waiting();
    t_free();
    t_disc_remove();
    t_ignored();
    t_search();
    t_alloc_order();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule